// File: doc/BRIEF.md
# Parallel bus read initiator

This block is the initiating side of a shared bus whose address and data travel on the same 32 lines. It performs single-word and burst reads. A local request stream hands it a start address, a bus command, one set of byte enables and a word count. The block then runs one bus transaction. It drives the address phase, releases the shared lines for a turnaround cycle and holds the byte enables on the command lines through every data phase. It captures each word on a rising edge where its own ready and the target's ready are both low, with the target's select also low. Before the last word it negates the frame signal, keeping its own ready asserted while it does so.

Returned words leave on a valid/ready stream that is backed by a two-entry queue. Back-pressure works as follows. A word is held, unchanged, until the consumer takes it. While the queue holds as many unread words as it has entries, the block negates its initiator-ready line, so the target inserts wait cycles and no word is lost. A new request is taken only when the block is idle and every word of the previous transaction has been read out. If no target claims the cycle within five clocks after the address phase, the block ends the transaction and pulses an abort flag.

Top module: `pbus_read_master`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in progress and the read queue is empty; a request is taken on a rising edge with `req_valid` and `req_ready` both high.
- R2: In the cycle after a request is taken, the block holds `frame_n` low, `irdy_n` high and `ad_oe` high, and drives `ad_out` with the address and `cbe_n` with the command code. This address phase lasts exactly one cycle.
- R3: From the cycle after the address phase until the transaction ends, `ad_oe` is low and `cbe_n` carries the inverted byte enables (`cbe_n[i]` low means byte lane i is used).
- R4: A word is captured only on an edge where `irdy_n`, `trdy_n` and `devsel_n` are all low. Any other edge is a wait cycle, and the word index does not advance on it.
- R5: `frame_n` goes high in the first cycle in which count-1 words have transferred and `irdy_n` is low, and it then stays high. A count of 1 negates it in the first data phase, and a count of 0 is treated as 1.
- R6: In the cycle after the final transfer, `frame_n` and `irdy_n` are both high. The final word leaves with `rd_last` high, and every other word leaves with it low.
- R7: Words leave in transfer order. `rd_valid` is high exactly while the queue is not empty. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_last` do not change.
- R8: During data phases, `irdy_n` is high exactly when the queue holds two unread words. Once `frame_n` is high, `irdy_n` stays low until the final word transfers.
- R9: If `devsel_n` is high on each of the five edges after the address phase, then in the next cycle `frame_n` and `irdy_n` are high, `xfer_abort` is high for that one cycle, and no word is returned. A claim seen on the fifth edge does not abort the transaction.
- R10: Under reset, `frame_n` and `irdy_n` are high, `ad_oe`, `rd_valid` and `xfer_abort` are low, and `cbe_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Start address |
| req_cmd | input | 4 | Bus command code |
| req_be | input | 4 | Byte enables for every data phase, active high |
| req_count | input | 8 | Number of words, 0 read as 1 |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer accepts the word |
| rd_data | output | 32 | Read word |
| rd_last | output | 1 | Word is the final one of its transaction |
| xfer_abort | output | 1 | One-cycle pulse: no target claimed the cycle |
| frame_n | output | 1 | Frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| ad_out | output | 32 | Address/data lines, driven value |
| ad_oe | output | 1 | Output enable for the address/data lines |
| ad_in | input | 32 | Address/data lines, sampled value |
| cbe_n | output | 4 | Command in the address phase, inverted byte enables afterwards |

## Verification
The hardest case to reach is a burst that reaches its final phase while the read queue is full. `irdy_n` must then stay high until a slot frees, and only then may `frame_n` rise with it low. A second hard case is a target that claims on exactly the fifth edge. The bench reaches both with directed transactions: a long burst with a consumer that is rarely ready, and a claim delay of five. Randomized transactions around these mix target waits, claim delays, absent targets and consumer stalls, so that the queue limit and the final phase meet in many different orders.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } pbr_state_e;
endpackage

// File: rtl/pbr_fifo.sv
module pbr_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop_ready,
  output logic         out_valid,
  output logic [W-1:0] rdata,
  output logic         space_next
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, count_nxt;
  logic             pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (count != '0);
  assign rdata     = mem[rd_ptr];
  assign pop       = out_valid && pop_ready;

  always_comb begin
    unique case ({push, pop})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  assign space_next = (count_nxt != FULL_CNT);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count_nxt;
    end
  end

  // R8: the initiator-ready gating must never let a word arrive into a full queue
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != FULL_CNT || pop));

  // R7: a held word stays put until taken
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> (out_valid && $stable(rdata)));
endmodule

// File: rtl/pbr_claim_timer.sv
module pbr_claim_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic devsel_n,
  output logic timeout
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] edges;
  logic             claimed_q;

  assign timeout = active && !claimed_q && devsel_n && (edges == LAST_EDGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edges     <= '0;
      claimed_q <= 1'b0;
    end else if (start) begin
      edges     <= '0;
      claimed_q <= 1'b0;
    end else if (active) begin
      if (!devsel_n) claimed_q <= 1'b1;
      else if (!claimed_q && edges != LAST_EDGE) edges <= edges + 1'b1;
    end
  end

  // R9: the window ends the transaction, so a timeout cannot repeat
  p_timeout_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R9: a claimed cycle never times out
  p_claim_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !devsel_n) |=> !timeout);
endmodule

// File: rtl/pbr_beat_ctr.sv
module pbr_beat_ctr #(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_val,
  input  logic               dec,
  output logic               one_left_next
);
  logic [COUNT_W-1:0] remaining, rem_after;

  assign rem_after     = dec ? remaining - 1'b1 : remaining;
  assign one_left_next = load ? (load_val <= COUNT_W'(1)) : (rem_after == COUNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) remaining <= '0;
    else if (load) remaining <= (load_val == '0) ? COUNT_W'(1) : load_val;
    else remaining <= rem_after;
  end

  // R5: the bus never moves more words than were asked for
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (remaining != '0));
endmodule

// File: rtl/pbus_read_master.sv
module pbus_read_master
  import pbr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int COUNT_W     = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int CLAIM_LIMIT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [DATA_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_cmd,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [COUNT_W-1:0]  req_count,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_last,
  output logic                xfer_abort,
  output logic                frame_n,
  output logic                irdy_n,
  input  logic                trdy_n,
  input  logic                devsel_n,
  output logic [DATA_W-1:0]   ad_out,
  output logic                ad_oe,
  input  logic [DATA_W-1:0]   ad_in,
  output logic [DATA_W/8-1:0] cbe_n
);
  localparam int LANES = DATA_W / 8;
  localparam int QW    = DATA_W + 1;

  pbr_state_e        state;
  logic              frame_q, irdy_q, oe_q, abort_q;
  logic [DATA_W-1:0] addr_q;
  logic [LANES-1:0]  cbe_q, be_n_q;

  logic          accept, xfer, last_xfer, timeout, space_next, one_left_next;
  logic [QW-1:0] q_rdata;

  assign frame_n    = frame_q;
  assign irdy_n     = irdy_q;
  assign ad_oe      = oe_q;
  assign ad_out     = addr_q;
  assign cbe_n      = cbe_q;
  assign xfer_abort = abort_q;

  assign req_ready = (state == ST_IDLE) && !rd_valid;
  assign accept    = req_valid && req_ready;
  assign xfer      = (state == ST_DATA) && !irdy_q && !trdy_n && !devsel_n;
  assign last_xfer = xfer && frame_q;

  pbr_fifo #(.W(QW), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (xfer),
    .wdata      ({frame_q, ad_in}),
    .pop_ready  (rd_ready),
    .out_valid  (rd_valid),
    .rdata      (q_rdata),
    .space_next (space_next)
  );
  assign rd_last = q_rdata[QW-1];
  assign rd_data = q_rdata[DATA_W-1:0];

  pbr_claim_timer #(.LIMIT(CLAIM_LIMIT)) u_claim (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (state == ST_ADDR),
    .active   (state == ST_DATA),
    .devsel_n (devsel_n),
    .timeout  (timeout)
  );

  pbr_beat_ctr #(.COUNT_W(COUNT_W)) u_beats (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (accept),
    .load_val      (req_count),
    .dec           (xfer),
    .one_left_next (one_left_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      frame_q <= 1'b1;
      irdy_q  <= 1'b1;
      oe_q    <= 1'b0;
      abort_q <= 1'b0;
      addr_q  <= '0;
      cbe_q   <= '1;
      be_n_q  <= '1;
    end else begin
      abort_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_ADDR;
            frame_q <= 1'b0;
            oe_q    <= 1'b1;
            addr_q  <= req_addr;
            cbe_q   <= req_cmd;
            be_n_q  <= ~req_be;
          end
        end
        ST_ADDR: begin
          state   <= ST_DATA;
          oe_q    <= 1'b0;
          addr_q  <= '0;
          cbe_q   <= be_n_q;
          irdy_q  <= !space_next;
          frame_q <= one_left_next && space_next;
        end
        ST_DATA: begin
          if (last_xfer || timeout) begin
            state   <= ST_IDLE;
            frame_q <= 1'b1;
            irdy_q  <= 1'b1;
            cbe_q   <= '1;
            abort_q <= timeout;
          end else begin
            irdy_q  <= !space_next;
            frame_q <= frame_q || (one_left_next && space_next);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: address is driven for one cycle, then the lines are released
  p_addr_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> !ad_oe);

  // R2: the address phase has frame asserted and initiator-ready negated
  p_addr_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!frame_n && irdy_n));

  // R1: a taken request leads straight into an address phase
  p_accept_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ad_oe);

  // R5: frame is released only while initiator-ready is asserted
  p_frame_needs_irdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && frame_n) |-> !irdy_n);

  // R8: in the final phase initiator-ready holds until the word moves
  p_irdy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && frame_n && !irdy_n && !xfer && !timeout) |=> !irdy_n);

  // R6: both control lines are released right after the final word
  p_release_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer |=> (frame_n && irdy_n && !xfer_abort));

  // R9: abort pulse lasts one cycle and comes with the bus released
  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> (frame_n && irdy_n && !$past(xfer_abort)));
endmodule

// File: tb/pbus_read_master_test.sv
module pbus_read_master_test;
  localparam int NT = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [3:0]  req_be = '0;
  logic [7:0]  req_count = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        rd_last;
  logic        xfer_abort;
  logic        frame_n, irdy_n;
  logic        trdy_n = 1'b1;
  logic        devsel_n = 1'b1;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n;

  always #5 clk = ~clk;

  pbus_read_master uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_be(req_be), .req_count(req_count),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .xfer_abort(xfer_abort), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .cbe_n(cbe_n)
  );

  int total = 0;
  int bad = 0;

  logic [31:0] t_addr [NT];
  logic [3:0]  t_cmd  [NT];
  logic [3:0]  t_be   [NT];
  int          t_cnt  [NT];
  int          t_dly  [NT];
  int          t_wait [NT];
  int          t_rdy  [NT];

  logic [32:0] expq[$];

  int nxt = 0, cur = 0, phase = 0, k = 0, done = 0, queued = 0;
  bit acc_prev = 0, sticky = 0, end_next = 0;
  bit prev_hold = 0;
  logic [32:0] prev_word = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [31:0] a, input int i);
    return (a + 32'(i) * 32'd4) ^ 32'h5A3C_0000 ^ {16'(i), 16'h0};
  endfunction

  function automatic int eff_cnt(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic set_txn(input int i, input logic [31:0] a, input int c, input int d,
                         input int w, input int r);
    t_addr[i] = a; t_cmd[i] = 4'h6; t_be[i] = 4'hF;
    t_cnt[i] = c; t_dly[i] = d; t_wait[i] = w; t_rdy[i] = r;
  endtask

  task automatic step();
    bit push = 0, pop = 0;
    bit fh_exp, claim;
    // bus phase tracking and target model
    if (acc_prev) begin
      // R2: address phase in the cycle after acceptance
      chk(!frame_n && ad_oe && irdy_n, "R2 ctl", {frame_n, ad_oe, irdy_n}, 3'b011);
      chk(ad_out == t_addr[cur], "R2 addr", ad_out, t_addr[cur]);
      chk(cbe_n == t_cmd[cur], "R2 cmd", cbe_n, t_cmd[cur]);
      phase = 1; k = 0; done = 0; sticky = 0; end_next = 0;
      devsel_n = 1; trdy_n = 1; acc_prev = 0;
    end else if (phase == 1) begin
      if (end_next) begin
        chk(frame_n && irdy_n, "R6 release", {frame_n, irdy_n}, 2'b11);
        phase = 0; devsel_n = 1; trdy_n = 1;
      end else begin
        k++;
        if (t_dly[cur] == 0 && k == 6) begin
          chk(xfer_abort && frame_n && irdy_n, "R9 abort", {xfer_abort, frame_n, irdy_n}, 3'b111);
          phase = 0; devsel_n = 1; trdy_n = 1;
        end else begin
          chk(!xfer_abort, "R9 no abort", xfer_abort, 0);
          chk(!ad_oe, "R3 released", ad_oe, 0);
          chk(cbe_n == ~t_be[cur], "R3 byte enables", cbe_n, ~t_be[cur]);
          chk(irdy_n == (queued >= 2), "R8 irdy gating", irdy_n, (queued >= 2));
          fh_exp = sticky || (done == eff_cnt(t_cnt[cur]) - 1 && !irdy_n);
          chk(frame_n == fh_exp, "R5 frame", frame_n, fh_exp);
          sticky = fh_exp;
          claim = (t_dly[cur] != 0) && (k >= t_dly[cur]);
          devsel_n = !claim;
          trdy_n = !(claim && k >= 2 && ($urandom % 100) >= t_wait[cur]);
          ad_in = word_of(t_addr[cur], done);
          // R4: transfer only when all three are low at the coming edge
          if (!irdy_n && !trdy_n && !devsel_n) begin
            expq.push_back({frame_n, ad_in});
            done++; push = 1;
            if (frame_n) end_next = 1;
          end
        end
      end
    end
    // consumer
    chk(rd_valid == (queued > 0), "R7 valid", rd_valid, (queued > 0));
    if (prev_hold)
      chk({rd_last, rd_data} == prev_word, "R7 stable", {rd_last, rd_data}, prev_word);
    rd_ready = (($urandom % 100) < t_rdy[cur]);
    if (rd_valid && rd_ready) begin
      if (expq.size() == 0) chk(0, "R4 extra word", rd_data, 0);
      else begin
        // R4 R6 R7: order, content and last flag
        chk({rd_last, rd_data} == expq[0], "R4 R6 R7 word", {rd_last, rd_data}, expq[0]);
        void'(expq.pop_front());
      end
      pop = 1;
    end
    prev_hold = rd_valid && !rd_ready;
    prev_word = {rd_last, rd_data};
    // R1: readiness follows idle and empty queue
    chk(req_ready == (phase == 0 && queued == 0), "R1 ready", req_ready, (phase == 0 && queued == 0));
    // driver
    if (nxt < NT && ($urandom % 4) != 0) begin
      req_valid = 1; req_addr = t_addr[nxt]; req_cmd = t_cmd[nxt];
      req_be = t_be[nxt]; req_count = 8'(t_cnt[nxt]);
    end else req_valid = 0;
    if (req_valid && req_ready) begin
      cur = nxt; nxt++; acc_prev = 1;
    end
    queued = queued + int'(push) - int'(pop);
  endtask

  initial begin
    int cyc = 0;
    // directed corner cases
    set_txn(0, 32'h0000_1000, 1, 1, 0, 100);
    set_txn(1, 32'h0000_2000, 4, 2, 0, 100);
    set_txn(2, 32'h0000_3000, 3, 5, 30, 100);  // claim on the fifth edge
    set_txn(3, 32'h0000_4000, 2, 0, 0, 100);   // nobody claims
    set_txn(4, 32'h0000_5000, 0, 3, 0, 100);   // count 0 acts as 1
    set_txn(5, 32'h0000_6000, 8, 1, 0, 10);    // heavy back-pressure
    set_txn(6, 32'h0000_7000, 255, 1, 10, 90); // longest burst
    set_txn(7, 32'h0000_8000, 2, 1, 0, 5);
    for (int i = 8; i < NT; i++) begin
      set_txn(i, $urandom & 32'hFFFF_FFFC, 1 + ($urandom % 9), 1 + ($urandom % 5),
              $urandom % 60, 20 + ($urandom % 81));
      if ($urandom % 8 == 0) t_dly[i] = 0;
      if ($urandom % 10 == 0) t_cnt[i] = 0;
      t_cmd[i] = ($urandom % 2) ? 4'h6 : 4'hE;
      t_be[i] = 4'($urandom);
    end
    t_be[1] = 4'b0101;
    t_rdy[0] = 100;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(frame_n && irdy_n && !ad_oe && !rd_valid && !xfer_abort, "R10 reset",
        {frame_n, irdy_n, ad_oe, rd_valid, xfer_abort}, 5'b11000);
    chk(cbe_n == 4'hF, "R10 cbe", cbe_n, 4'hF);
    rst_n = 1;
    while ((nxt < NT || phase != 0 || acc_prev || queued != 0) && cyc < 100000) begin
      @(negedge clk);
      step();
      cyc++;
    end
    if (cyc >= 100000) chk(0, "watchdog", cyc, 100000);
    chk(expq.size() == 0, "R7 drained", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule